// File: doc/BRIEF.md
# Smart card character receiver

This block receives asynchronous characters from the I/O line of a smart card. While the line idles high, a falling edge starts a character. The block then times the character with a half-ETU tick that is generated elsewhere. That tick is a single-clock pulse, issued twice per elementary time unit. The block checks the start bit again at its centre to reject glitches. It then samples eight data bits and one parity bit at the centre of each bit. Data arrives least significant bit first, with a high level read as 1. The result is written to a receive register that the host reads.

All status is updated together at 10.5 ETU after the start edge. The status consists of a full flag, an empty flag, a parity error flag and an active-low interrupt. A parity error is handled according to the protocol in use. Under T=0 the faulty character is dropped. Under T=1 it is kept. In synchronous-card mode, character reception stops and bit 0 of the receive data follows the card line.

Top module: `scr_char_rx`

## Requirements
- R1: After reset, rx_data is 0, rx_full is 0, par_err is 0, rx_empty is 1 and irq_n is 1.
- R2: A falling edge on card_io starts a character. Data bits are taken least significant first, with high meaning 1, at 1.5 to 8.5 ETU. The parity bit is taken at 9.5 ETU. Parity is even: the nine sampled bits hold an even number of ones.
- R3: If card_io is high at the 0.5 ETU sample, the character is abandoned and no output changes.
- R4: Flags change only at the 21st half-ETU tick after start detection (10.5 ETU), never earlier.
- R5: A character with good parity is stored in rx_data. This sets rx_full and clears rx_empty.
- R6: With proto_t1 = 0 (T=0), a parity error sets par_err. The character is discarded, and rx_data and rx_full are unchanged.
- R7: With proto_t1 = 1 (T=1), a parity error sets par_err, and the character is still stored with rx_full set.
- R8: A one-cycle rd_data pulse clears rx_full and sets rx_empty. A store in the same cycle takes priority, so the new character leaves rx_full set.
- R9: irq_n goes low when a character completes, whether it is stored or has a parity error. A rd_status pulse returns irq_n high and clears par_err.
- R10: While sync_mode is 1, rx_data is {7'b0, card_io} after a two-flop synchronizer, and falling edges start no character.

Parity error and rx_full are computed independently, so R6 and R7 hold whether or not rx_full was already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle pulse, twice per ETU |
| card_io | input | 1 | Card I/O line, idle high |
| proto_t1 | input | 1 | 0 selects T=0, 1 selects T=1 |
| sync_mode | input | 1 | Synchronous-card mode |
| rd_data | input | 1 | Host read of receive register |
| rd_status | input | 1 | Host read of status |
| rx_data | output | 8 | Receive register, or line level in sync mode |
| rx_full | output | 1 | Receive buffer full |
| par_err | output | 1 | Parity error flag |
| rx_empty | output | 1 | Receive buffer empty |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sends characters whose parity is deliberately wrong under both protocols. A design that mixed up the protocols would overwrite the held character under T=0 or lose it under T=1. It checks that the full flag is still clear just before the 10.5 ETU tick, which catches flags raised one half-ETU early. It sends a short low glitch that a missing start recheck would turn into a phantom character. It places a host read exactly on the store cycle, where the wrong priority drops a new character. Finally, the sync-mode test shows the line level rather than the held data, which exposes a wrong output multiplexer.

// File: rtl/scr_rx_pkg.sv
package scr_rx_pkg;
  typedef enum logic {FRM_IDLE, FRM_BUSY} frm_state_t;

  // Half-ETU positions, counted from start detection.
  localparam int START_CHK_HT = 1;

  function automatic int last_sample_ht(input int data_w);
    return 2 * (data_w + 1) + 1;
  endfunction
endpackage

// File: rtl/scr_rx_sync.sv
module scr_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[gi] <= 1'b1;
        else     chain[gi] <= chain[gi-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/scr_rx_frame.sv
module scr_rx_frame
  import scr_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              half_tick,
  input  logic              level,
  input  logic              fall,
  output logic              done,
  output logic              par_bad,
  output logic [DATA_W-1:0] data
);
  localparam int BITS    = DATA_W + 1;
  localparam int LAST_HT = last_sample_ht(DATA_W);
  localparam int DONE_HT = LAST_HT + 2;
  localparam int CW      = $clog2(DONE_HT + 1);
  localparam logic [CW-1:0] K_CHK   = CW'(START_CHK_HT);
  localparam logic [CW-1:0] K_FIRST = CW'(3);
  localparam logic [CW-1:0] K_LAST  = CW'(LAST_HT);
  localparam logic [CW-1:0] K_DONE  = CW'(DONE_HT);

  frm_state_t        state_q;
  logic [CW-1:0]     hcnt_q;
  logic [BITS-1:0]   sh_q;
  logic [CW-1:0]     hnext;

  assign hnext = hcnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FRM_IDLE;
      hcnt_q  <= '0;
      sh_q    <= '0;
      done    <= 1'b0;
      par_bad <= 1'b0;
      data    <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        FRM_IDLE: begin
          if (enable && fall) begin
            state_q <= FRM_BUSY;
            hcnt_q  <= '0;
          end
        end
        default: begin
          if (!enable) begin
            state_q <= FRM_IDLE;
          end else if (half_tick) begin
            hcnt_q <= hnext;
            if (hnext == K_CHK && level) begin
              state_q <= FRM_IDLE;
            end else if (hnext >= K_FIRST && hnext <= K_LAST && hnext[0]) begin
              sh_q <= {level, sh_q[BITS-1:1]};
            end else if (hnext == K_DONE) begin
              done    <= 1'b1;
              data    <= sh_q[DATA_W-1:0];
              par_bad <= ^sh_q;
              state_q <= FRM_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/scr_rx_regs.sv
module scr_rx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              par_bad,
  input  logic [DATA_W-1:0] frm_data,
  input  logic              proto_t1,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              empty_q,
  output logic              perr_q,
  output logic              irq_n_q
);
  logic store;
  assign store = done && (!par_bad || proto_t1);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      perr_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      if (store) begin
        data_q  <= frm_data;
        full_q  <= 1'b1;
        empty_q <= 1'b0;
      end else if (rd_data) begin
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end
      if (done && par_bad) perr_q <= 1'b1;
      else if (rd_status)  perr_q <= 1'b0;
      if (done)           irq_n_q <= 1'b0;
      else if (rd_status) irq_n_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scr_char_rx.sv
module scr_char_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_tick,
  input  logic              card_io,
  input  logic              proto_t1,
  input  logic              sync_mode,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              par_err,
  output logic              rx_empty,
  output logic              irq_n
);
  logic              io_level;
  logic              io_fall;
  logic              frm_done;
  logic              frm_bad;
  logic [DATA_W-1:0] frm_data;
  logic [DATA_W-1:0] held_data;

  scr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (card_io),
    .level (io_level),
    .fall  (io_fall)
  );

  scr_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .enable    (!sync_mode),
    .half_tick (half_tick),
    .level     (io_level),
    .fall      (io_fall),
    .done      (frm_done),
    .par_bad   (frm_bad),
    .data      (frm_data)
  );

  scr_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .done      (frm_done),
    .par_bad   (frm_bad),
    .frm_data  (frm_data),
    .proto_t1  (proto_t1),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .data_q    (held_data),
    .full_q    (rx_full),
    .empty_q   (rx_empty),
    .perr_q    (par_err),
    .irq_n_q   (irq_n)
  );

  assign rx_data = sync_mode ? {{(DATA_W-1){1'b0}}, io_level} : held_data;
endmodule

// File: rtl/scr_char_rx_chk.sv
module scr_char_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              proto_t1,
  input logic              sync_mode,
  input logic              rd_data,
  input logic              rd_status,
  input logic              frm_done,
  input logic              frm_bad,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              rx_empty,
  input logic              par_err,
  input logic              irq_n
);
  assert_full_only_on_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(frm_done));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    frm_done |=> !frm_done);

  assert_good_store_R5: assert property (@(posedge clk) disable iff (rst)
    frm_done && !frm_bad |=> rx_full && !rx_empty);

  assert_t0_discard_R6: assert property (@(posedge clk) disable iff (rst)
    frm_done && frm_bad && !proto_t1 |=> par_err && (sync_mode || $stable(rx_data)));

  assert_t1_keep_R7: assert property (@(posedge clk) disable iff (rst)
    frm_done && frm_bad && proto_t1 |=> par_err && rx_full);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
    rd_data && !frm_done |=> !rx_full && rx_empty);

  assert_status_release_R9: assert property (@(posedge clk) disable iff (rst)
    rd_status && !frm_done |=> irq_n && !par_err);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(frm_done));
endmodule

bind scr_char_rx scr_char_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .proto_t1  (proto_t1),
  .sync_mode (sync_mode),
  .rd_data   (rd_data),
  .rd_status (rd_status),
  .frm_done  (frm_done),
  .frm_bad   (frm_bad),
  .rx_data   (rx_data),
  .rx_full   (rx_full),
  .rx_empty  (rx_empty),
  .par_err   (par_err),
  .irq_n     (irq_n)
);

// File: tb/scr_char_rx_tb.sv
`timescale 1ns/1ps
module scr_char_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_tick = 1'b0;
  logic       card_io = 1'b1;
  logic       proto_t1 = 1'b0;
  logic       sync_mode = 1'b0;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, par_err, rx_empty, irq_n;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 1'b0;

  scr_char_rx u_dut (
    .clk(clk), .rst(rst), .half_tick(half_tick), .card_io(card_io),
    .proto_t1(proto_t1), .sync_mode(sync_mode), .rd_data(rd_data),
    .rd_status(rd_status), .rx_data(rx_data), .rx_full(rx_full),
    .par_err(par_err), .rx_empty(rx_empty), .irq_n(irq_n)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_tick();
    do @(posedge clk); while (!half_tick);
    @(negedge clk);
  endtask

  // Drives start, data LSB first, parity; returns just after the 20th half tick.
  task automatic send_frame(input logic [7:0] d, input logic bad);
    next_tick();
    card_io = 1'b0;
    for (int i = 0; i < 8; i++) begin
      next_tick(); next_tick();
      card_io = d[i];
    end
    next_tick(); next_tick();
    card_io = (^d) ^ bad;
    next_tick(); next_tick();
    card_io = 1'b1;
  endtask

  task automatic finish_frame(input logic rd_on_store);
    next_tick();
    if (rd_on_store) begin
      rd_data = 1'b1;
      @(negedge clk);
      rd_data = 1'b0;
      @(negedge clk);
    end else begin
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse_status();
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_read();
    rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 rx_data", rx_data, 8'h00);
    check("R1 rx_full", rx_full, 0);
    check("R1 par_err", par_err, 0);
    check("R1 rx_empty", rx_empty, 1);
    check("R1 irq_n", irq_n, 1);
  endtask

  task automatic test_t0_good();
    proto_t1 = 1'b0;
    send_frame(8'hA5, 1'b0);
    check("R4 full before 10.5 ETU", rx_full, 0);
    finish_frame(1'b0);
    check("R5 full set", rx_full, 1);
    check("R5 empty cleared", rx_empty, 0);
    check("R2 data A5", rx_data, 8'hA5);
    check("R9 irq low on store", irq_n, 0);
    pulse_status();
    check("R9 irq released", irq_n, 1);
    pulse_read();
    check("R8 full cleared", rx_full, 0);
    check("R8 empty set", rx_empty, 1);
    send_frame(8'h81, 1'b0);
    finish_frame(1'b0);
    check("R2 data 81 bit order", rx_data, 8'h81);
    pulse_status(); pulse_read();
  endtask

  task automatic test_t0_parity();
    proto_t1 = 1'b0;
    send_frame(8'h3C, 1'b1);
    finish_frame(1'b0);
    check("R6 par_err set", par_err, 1);
    check("R6 full unchanged", rx_full, 0);
    check("R6 data unchanged", rx_data, 8'h81);
    check("R9 irq low on parity", irq_n, 0);
    pulse_status();
    check("R9 par_err cleared", par_err, 0);
    check("R9 irq released", irq_n, 1);
  endtask

  task automatic test_t1();
    proto_t1 = 1'b1;
    send_frame(8'h5A, 1'b1);
    finish_frame(1'b0);
    check("R7 par_err set", par_err, 1);
    check("R7 full set", rx_full, 1);
    check("R7 data stored", rx_data, 8'h5A);
    pulse_status(); pulse_read();
    send_frame(8'h7E, 1'b0);
    finish_frame(1'b0);
    check("R7 good T1 data", rx_data, 8'h7E);
    check("R7 good T1 no par_err", par_err, 0);
    pulse_status(); pulse_read();
    proto_t1 = 1'b0;
  endtask

  task automatic test_glitch();
    next_tick();
    card_io = 1'b0;
    repeat (4) @(negedge clk);
    card_io = 1'b1;
    repeat (24) next_tick();
    check("R3 no store after glitch", rx_full, 0);
    check("R3 no par_err after glitch", par_err, 0);
    check("R3 irq idle after glitch", irq_n, 1);
    check("R3 data held", rx_data, 8'h7E);
  endtask

  task automatic test_collision();
    send_frame(8'h11, 1'b0);
    finish_frame(1'b0);
    send_frame(8'h22, 1'b0);
    finish_frame(1'b1);
    check("R8 store wins over read", rx_full, 1);
    check("R8 new data", rx_data, 8'h22);
    pulse_status(); pulse_read();
  endtask

  task automatic test_sync();
    sync_mode = 1'b1;
    card_io = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 mirrors low", rx_data, 8'h00);
    card_io = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 mirrors high", rx_data, 8'h01);
    send_frame(8'h00, 1'b0);
    finish_frame(1'b0);
    check("R10 no frame in sync mode", rx_full, 0);
    check("R10 no irq in sync mode", irq_n, 1);
    sync_mode = 1'b0;
    @(negedge clk);
    check("R10 held data back", rx_data, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_t0_good();
    test_t0_parity();
    test_t1();
    test_glitch();
    test_collision();
    test_sync();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule